// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit sits between a processor's address generator and its memory bus. Each access arrives as a request that carries a logical address and an access kind: read, write or execute. The processor also supplies a privilege level. In user mode the unit compares the address against a privileged limit and adds a privileged base to form the physical address. Both operations happen in the cycle the request is presented. An access that fails the check never reaches the bus. The unit records its address and kind in a sticky fault record, where the trap logic can read them. Supervisor accesses pass straight through with no translation and no check.

The base, the limit and a compare-mode bit are loaded together by one write strobe. That strobe is honoured only in supervisor mode. In the alternative bound mode the second register holds an inclusive upper physical address, and the check is made on the sum. In either mode a carry out of the addition counts as a fault.

The request and bus sides follow valid/ready rules. A request that passes is forwarded combinationally, and it is consumed only when the bus accepts it, so `req_ready` follows `bus_ready`. A faulting request is consumed at once with `req_ready` high and `bus_valid` low, whatever the bus does. `bus_valid` never depends on `bus_ready`. The fault pins and the configuration pins are plain level signals.

Top module: `base_limit_xlate`

## Requirements
- R1: After reset the fault record is clear, and base, limit and mode are zero, with mode 0 meaning limit compare. A user access issued before any configuration therefore faults, because a zero limit admits no address.
- R2: With `priv_super` high, `bus_addr` equals `req_addr`, `flt_now` stays low and `bus_valid` follows `req_valid`, whatever the address.
- R3: In user mode with mode 0, an address below the limit gives `bus_addr = base + req_addr` and `bus_valid` high in the same cycle. `bus_kind` repeats `req_kind`.
- R4: In user mode with mode 0, an address greater than or equal to the limit raises `flt_now`. It holds `bus_valid` low and drives `req_ready` high, so the request is dropped.
- R5: In user mode, a carry out of `base + req_addr` at the address width is a fault in either compare mode.
- R6: In user mode with mode 1, an access passes when `base + req_addr` is at most the bound register, and faults otherwise.
- R7: A configuration write with `priv_super` low changes none of base, limit or mode.
- R8: One `cfg_we` pulse in supervisor mode loads base, limit and mode together on the same clock edge.
- R9: At the first faulting request, the next edge sets `flt_sticky` and captures `flt_addr = req_addr` and `flt_kind = req_kind`. The kind codes are read 2'b00, write 2'b01 and execute 2'b10.
- R10: While `flt_sticky` is set, later faults leave `flt_addr` and `flt_kind` unchanged.
- R11: `flt_ack` clears `flt_sticky` only when `priv_super` is high. An acknowledge in user mode is ignored.
- R12: For a passing request, `req_ready` equals `bus_ready`, and a stalled request keeps `bus_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_super | input | 1 | 1 = supervisor, 0 = user |
| cfg_we | input | 1 | Combined configuration write strobe |
| cfg_base | input | AW | New base value |
| cfg_limit | input | AW | New limit (mode 0) or inclusive bound (mode 1) |
| cfg_mode | input | 1 | 0 = limit compare, 1 = bound compare |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request consumed |
| req_addr | input | AW | Logical address |
| req_kind | input | 2 | Access kind |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts |
| bus_addr | output | AW | Physical address |
| bus_kind | output | 2 | Access kind toward the bus |
| flt_now | output | 1 | Current request violates protection |
| flt_ack | input | 1 | Fault acknowledge (supervisor only) |
| flt_sticky | output | 1 | Fault record held |
| flt_addr | output | AW | Captured faulting logical address |
| flt_kind | output | 2 | Captured faulting access kind |

## Verification
The bench goes after the edges of the window. Logical 0xFFFF passes at base 0x40000 with limit 0x10000, and 0x10000 faults. An off-by-one compare would let the first address past the top reach the bus, or would refuse the last legal one. Wrap-around cases check that a design ignoring the carry does not forward a wrapped low physical address, and the bound-mode cases check that the bound is inclusive. It also confirms that user-mode configuration writes and acknowledges change nothing, and that a second fault does not overwrite the first record. A faulting request must be dropped even while the bus stalls. A design that gated the drop on `bus_ready` would hang the processor here.

// File: rtl/blx_pkg.sv
package blx_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'b00,
    ACC_WR = 2'b01,
    ACC_EX = 2'b10
  } acc_e;

  typedef enum logic {
    CMP_LIMIT = 1'b0,
    CMP_BOUND = 1'b1
  } cmp_e;
endpackage

// File: rtl/blx_regs.sv
module blx_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_super,
  input  logic          we,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] lim_in,
  input  logic          mode_in,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] lim_q,
  output logic          mode_q
);
  import blx_pkg::*;

  logic load;
  assign load = we & priv_super;

  // One strobe moves all three fields, so no cycle mixes old and new.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      mode_q <= CMP_LIMIT;
    end else if (load) begin
      base_q <= base_in;
      lim_q  <= lim_in;
      mode_q <= mode_in;
    end
  end

  assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !priv_super) |=> (base_q == $past(base_q) && lim_q == $past(lim_q)
                             && mode_q == $past(mode_q)));

  assert_joint_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && priv_super) |=> (base_q == $past(base_in) && lim_q == $past(lim_in)
                            && mode_q == $past(mode_in)));
endmodule

// File: rtl/blx_check.sv
module blx_check #(
  parameter int AW = 32
) (
  input  logic          priv_super,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] lim,
  input  logic          mode,
  output logic [AW-1:0] phys,
  output logic          viol
);
  import blx_pkg::*;

  localparam int SW = AW + 1;

  logic [SW-1:0] sum;
  logic          carry;
  logic          over_lim;
  logic          over_bound;

  // Compare and add run side by side; neither waits on the other.
  always_comb begin
    sum        = {1'b0, base} + {1'b0, addr};
    carry      = sum[AW];
    over_lim   = (addr >= lim);
    over_bound = (sum[AW-1:0] > lim);
  end

  always_comb begin
    if (priv_super) begin
      phys = addr;
      viol = 1'b0;
    end else begin
      phys = sum[AW-1:0];
      if (mode == CMP_BOUND) viol = carry | over_bound;
      else                   viol = carry | over_lim;
    end
  end
endmodule

// File: rtl/blx_fault.sv
module blx_fault #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [AW-1:0] addr_in,
  input  logic [1:0]    kind_in,
  input  logic          ack_ok,
  output logic          sticky,
  output logic [AW-1:0] faddr,
  output logic [1:0]    fkind
);
  logic capture;
  assign capture = hit & (~sticky | ack_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= 1'b0;
      faddr  <= '0;
      fkind  <= 2'b00;
    end else begin
      sticky <= capture | (sticky & ~ack_ok);
      if (capture) begin
        faddr <= addr_in;
        fkind <= kind_in;
      end
    end
  end

  assert_record_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !ack_ok) |=> (sticky && $stable(faddr) && $stable(fkind)));

  assert_first_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sticky) |=> (sticky && faddr == $past(addr_in) && fkind == $past(kind_in)));
endmodule

// File: rtl/base_limit_xlate.sv
module base_limit_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_super,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic          cfg_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_kind,
  output logic          flt_now,
  input  logic          flt_ack,
  output logic          flt_sticky,
  output logic [AW-1:0] flt_addr,
  output logic [1:0]    flt_kind
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] lim_q;
  logic          mode_q;
  logic          viol;

  blx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .priv_super(priv_super), .we(cfg_we),
    .base_in(cfg_base), .lim_in(cfg_limit), .mode_in(cfg_mode),
    .base_q(base_q), .lim_q(lim_q), .mode_q(mode_q)
  );

  blx_check #(.AW(AW)) u_check (
    .priv_super(priv_super), .addr(req_addr), .base(base_q), .lim(lim_q),
    .mode(mode_q), .phys(bus_addr), .viol(viol)
  );

  // A violating request is swallowed here and never waits on the bus.
  assign flt_now   = req_valid & viol;
  assign bus_valid = req_valid & ~viol;
  assign req_ready = viol | bus_ready;
  assign bus_kind  = req_kind;

  blx_fault #(.AW(AW)) u_fault (
    .clk(clk), .rst_n(rst_n), .hit(flt_now), .addr_in(req_addr),
    .kind_in(req_kind), .ack_ok(flt_ack & priv_super),
    .sticky(flt_sticky), .faddr(flt_addr), .fkind(flt_kind)
  );

  assert_super_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_super) |-> (bus_valid && !flt_now && bus_addr == req_addr));

  assert_fault_blocks_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_now |-> (!bus_valid && req_ready));

  assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |-> !req_ready);

  assert_user_ack_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_sticky && flt_ack && !priv_super) |=> flt_sticky);
endmodule

// File: tb/sim_base_limit_xlate.sv
`timescale 1ns/1ps
module sim_base_limit_xlate;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          priv_super = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic          cfg_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = 2'b00;
  logic          bus_valid;
  logic          bus_ready = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_kind;
  logic          flt_now;
  logic          flt_ack = 1'b0;
  logic          flt_sticky;
  logic [AW-1:0] flt_addr;
  logic [1:0]    flt_kind;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  base_limit_xlate #(.AW(AW)) u0 (.*);

  // {super, addr, kind, expect_fault, expect_bus_addr}
  localparam int NV = 8;
  localparam logic [67:0] TBL [NV] = '{
    {1'b0, 32'h0000_0000, 2'b00, 1'b0, 32'h0004_0000},
    {1'b0, 32'h0000_FFFF, 2'b01, 1'b0, 32'h0004_FFFF},
    {1'b0, 32'h0001_0000, 2'b10, 1'b1, 32'h0000_0000},
    {1'b0, 32'h0000_1234, 2'b10, 1'b0, 32'h0004_1234},
    {1'b0, 32'h0002_0000, 2'b01, 1'b1, 32'h0000_0000},
    {1'b1, 32'h0002_0000, 2'b01, 1'b0, 32'h0002_0000},
    {1'b1, 32'hFFFF_FFFF, 2'b00, 1'b0, 32'hFFFF_FFFF},
    {1'b0, 32'hFFFF_FFFF, 2'b00, 1'b1, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic [31:0] a, input logic [1:0] k);
    @(negedge clk);
    priv_super = s; req_addr = a; req_kind = k; req_valid = 1'b1;
    #1;
  endtask

  task automatic cfgw(input logic s, input logic [31:0] b, input logic [31:0] l, input logic m);
    @(negedge clk);
    req_valid = 1'b0; priv_super = s; cfg_base = b; cfg_limit = l; cfg_mode = m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack(input logic s);
    @(negedge clk);
    req_valid = 1'b0; priv_super = s; flt_ack = 1'b1;
    @(negedge clk);
    flt_ack = 1'b0;
    #1;
  endtask

  task automatic expect_pass(input string tag, input logic [31:0] exp_addr);
    chk({tag, " flt_now"}, {31'd0, flt_now}, 32'd0);
    chk({tag, " bus_valid"}, {31'd0, bus_valid}, 32'd1);
    chk({tag, " bus_addr"}, bus_addr, exp_addr);
  endtask

  task automatic expect_fault(input string tag);
    chk({tag, " flt_now"}, {31'd0, flt_now}, 32'd1);
    chk({tag, " bus_valid"}, {31'd0, bus_valid}, 32'd0);
    chk({tag, " req_ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 sticky after reset", {31'd0, flt_sticky}, 32'd0);
    put(1'b0, 32'h0, 2'b00);
    expect_fault("R1 zero limit");

    cfgw(1'b0, 32'h0004_0000, 32'h0001_0000, 1'b0);
    put(1'b0, 32'h0, 2'b00);
    expect_fault("R7 user config ignored");

    ack(1'b1);
    chk("R11 supervisor ack clears", {31'd0, flt_sticky}, 32'd0);

    cfgw(1'b1, 32'h0004_0000, 32'h0001_0000, 1'b0);
    for (int i = 0; i < NV; i++) begin
      put(TBL[i][67], TBL[i][66:35], TBL[i][34:33]);
      if (TBL[i][32]) expect_fault($sformatf("R4 vec%0d", i));
      else begin
        expect_pass($sformatf("R3/R2 vec%0d", i), TBL[i][31:0]);
        chk($sformatf("R3 vec%0d bus_kind", i), {30'd0, bus_kind}, {30'd0, TBL[i][34:33]});
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R9 sticky set", {31'd0, flt_sticky}, 32'd1);
    chk("R9/R10 first fault addr kept", flt_addr, 32'h0001_0000);
    chk("R9/R10 first fault kind execute", {30'd0, flt_kind}, 32'd2);

    ack(1'b0);
    chk("R11 user ack ignored", {31'd0, flt_sticky}, 32'd1);
    chk("R11 record intact", flt_addr, 32'h0001_0000);
    ack(1'b1);
    chk("R11 cleared", {31'd0, flt_sticky}, 32'd0);

    cfgw(1'b1, 32'hFFFF_F000, 32'h0000_2000, 1'b0);
    put(1'b0, 32'h0000_0FFF, 2'b00);
    expect_pass("R5 top of space", 32'hFFFF_FFFF);
    put(1'b0, 32'h0000_1000, 2'b01);
    expect_fault("R5 carry limit mode");

    cfgw(1'b1, 32'h0000_1000, 32'h0000_1FFF, 1'b1);
    put(1'b0, 32'h0000_0FFF, 2'b00);
    expect_pass("R6 bound inclusive", 32'h0000_1FFF);
    put(1'b0, 32'h0000_1000, 2'b00);
    expect_fault("R6 above bound");
    put(1'b0, 32'h0000_0000, 2'b10);
    expect_pass("R6 at base", 32'h0000_1000);

    cfgw(1'b1, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1'b1);
    put(1'b0, 32'h0000_0100, 2'b00);
    expect_fault("R5 carry bound mode");

    cfgw(1'b1, 32'h0000_8000, 32'h0000_0100, 1'b0);
    put(1'b0, 32'h0000_00FF, 2'b00);
    expect_pass("R8 new base and limit", 32'h0000_80FF);
    put(1'b0, 32'h0000_0100, 2'b00);
    expect_fault("R8 new limit edge");

    put(1'b0, 32'h0000_0010, 2'b01);
    bus_ready = 1'b0;
    #1;
    chk("R12 stalled bus_valid", {31'd0, bus_valid}, 32'd1);
    chk("R12 stalled req_ready", {31'd0, req_ready}, 32'd0);
    put(1'b0, 32'h0000_0100, 2'b01);
    expect_fault("R12 fault drops under stall");
    bus_ready = 1'b1;
    #1;
    chk("R12 ready follows bus", {31'd0, req_ready}, 32'd1);

    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule